// File: doc/BRIEF.md
# Predicated Vector Element Expand Unit

The unit takes a source vector, a mask with one bit for each byte of the vector, and a 32-bit operation word. The operation word gives the element width and three register numbers. Source elements are read in order starting at element zero. Each one is placed into the next enabled lane of the result, and lanes are visited from lane zero upward. Every lane that is not enabled comes out as zero.

The vector width is fixed at build time and must be a multiple of 128 bits. The element width is chosen for each operation from the word and can be 8, 16, 32 or 64 bits. The unit takes one operation per cycle when `in_valid` is high and returns its result from a register stage one cycle later. It also reports the decoded register numbers and raises a flag for any word whose fixed opcode bits are wrong.

Top module: `vexp_unit`

## Requirements
- R1: Bits 23:22 of the operation word select the element width: 0 gives 8-bit, 1 gives 16-bit, 2 gives 32-bit and 3 gives 64-bit elements. The number of lanes is VLEN divided by that width, and `out_esz` echoes the code.
- R2: A lane is enabled only when the mask bit at the lowest byte of that lane is 1. The other mask bits under that lane have no effect on the result.
- R3: Counting enabled lanes from lane 0 upward, the k-th enabled lane receives source element k-1.
- R4: A lane that is not enabled is written with all zeros.
- R5: When no lane is enabled at the chosen width, the whole result is zero.
- R6: The decoded fields come from fixed bit positions in the word: `out_pg` from bits 12:10, `out_zn` from bits 9:5 and `out_zd` from bits 4:0.
- R7: A word whose bits 31:24 are not 8'h05, or whose bits 21:13 are not 9'b110001100, sets `out_bad` to 1 and forces the result to zero.
- R8: `out_valid` goes high exactly one cycle after `in_valid` is sampled high. An operation is accepted on every cycle, so back-to-back operations are supported.
- R9: While `rst` is high, `out_valid`, `out_bad` and `out_data` are cleared at the clock edge.
- R10: When `in_valid` is low, `out_data` and the decoded outputs keep their previous values.
- R11: The width parameter VLEN must be a multiple of 128. Both the 128-bit and the 256-bit builds follow R1 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_insn | input | 32 | Operation word |
| in_pred | input | VLEN/8 | Byte-granular lane mask |
| in_src | input | VLEN | Source vector |
| out_valid | output | 1 | Result valid |
| out_bad | output | 1 | Operation word did not match the fixed pattern |
| out_esz | output | 2 | Element width code of the result |
| out_pg | output | 3 | Mask register number |
| out_zn | output | 5 | Source register number |
| out_zd | output | 5 | Destination register number |
| out_data | output | VLEN | Expanded result |

## Verification
The expand function is tried with several mask patterns:
- An all-ones mask shows that the operation acts as a plain copy.
- An all-zeros mask gives a zero result.
- A mask with a single set bit shows that element 0 lands in exactly one lane, including the top lane.
- Alternating masks are applied at a width wider than a byte. The one with bits set only off the lane start enables nothing, which proves that the non-lowest mask bits are ignored.
- Sparse masks at the 32-bit and 64-bit widths show that lanes far apart are filled with consecutive source elements.
- Random masks at each width are checked against a sequential reference loop, in both the 128-bit and the 256-bit builds.

Directed cases cover the reset state, malformed words, the decoded field positions, back-to-back issue and holding of the outputs while idle.

// File: rtl/vexp_pkg.sv
package vexp_pkg;

  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_W = 2'd2,
    ESZ_D = 2'd3
  } esz_e;

  localparam logic [7:0] OPC_TOP = 8'h05;
  localparam logic [8:0] OPC_MID = 9'b110001100;
  localparam int         NUM_ESZ = 4;

  typedef struct packed {
    logic       bad;
    esz_e       esz;
    logic [2:0] pg;
    logic [4:0] zn;
    logic [4:0] zd;
  } insn_f_t;

  function automatic int elem_bits(input int code);
    return 8 << code;
  endfunction

endpackage

// File: rtl/vexp_decode.sv
module vexp_decode
  import vexp_pkg::*;
(
  input  logic [31:0] insn,
  output insn_f_t     fields
);
  always_comb begin
    fields.bad = (insn[31:24] != OPC_TOP) || (insn[21:13] != OPC_MID);
    fields.esz = esz_e'(insn[23:22]);
    fields.pg  = insn[12:10];
    fields.zn  = insn[9:5];
    fields.zd  = insn[4:0];
  end
endmodule

// File: rtl/vexp_lane_act.sv
module vexp_lane_act #(
  parameter int VLEN = 256,
  parameter int EW   = 8
) (
  input  logic [VLEN/8-1:0]  pred,
  output logic [VLEN/EW-1:0] act
);
  localparam int NL  = VLEN / EW;
  localparam int BPL = EW / 8;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign act[i] = pred[i*BPL];
  end
endmodule

// File: rtl/vexp_prefix.sv
module vexp_prefix #(
  parameter int NL = 32,
  localparam int IW = $clog2(NL) + 1
) (
  input  logic [NL-1:0]    act,
  output logic [NL*IW-1:0] idx
);
  always_comb begin
    logic [IW-1:0] run;
    run = '0;
    for (int i = 0; i < NL; i++) begin
      idx[i*IW +: IW] = run;
      run = run + IW'(act[i]);
    end
  end
endmodule

// File: rtl/vexp_steer.sv
module vexp_steer #(
  parameter int VLEN = 256,
  parameter int EW   = 8,
  localparam int NL = VLEN / EW,
  localparam int IW = $clog2(NL) + 1
) (
  input  logic [VLEN-1:0]  src,
  input  logic [NL-1:0]    act,
  input  logic [NL*IW-1:0] idx,
  output logic [VLEN-1:0]  res
);
  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [EW-1:0] pick;
    always_comb begin
      pick = '0;
      for (int j = 0; j <= i; j++) begin
        if (idx[i*IW +: IW] == IW'(j)) pick = src[j*EW +: EW];
      end
    end
    assign res[i*EW +: EW] = act[i] ? pick : '0;
  end
endmodule

// File: rtl/vexp_size_path.sv
module vexp_size_path #(
  parameter int VLEN = 256,
  parameter int EW   = 8
) (
  input  logic [VLEN-1:0]   src,
  input  logic [VLEN/8-1:0] pred,
  output logic [VLEN-1:0]   res
);
  localparam int NL = VLEN / EW;
  localparam int IW = $clog2(NL) + 1;

  logic [NL-1:0]    act;
  logic [NL*IW-1:0] idx;
  logic [VLEN-1:0]  steered;

  vexp_lane_act #(.VLEN(VLEN), .EW(EW)) u_act (
    .pred (pred),
    .act  (act)
  );

  vexp_prefix #(.NL(NL)) u_pfx (
    .act (act),
    .idx (idx)
  );

  vexp_steer #(.VLEN(VLEN), .EW(EW)) u_steer (
    .src (src),
    .act (act),
    .idx (idx),
    .res (steered)
  );

  assign res = (|act) ? steered : '0;
endmodule

// File: rtl/vexp_unit.sv
module vexp_unit
  import vexp_pkg::*;
#(
  parameter int VLEN = 256,
  localparam int PW = VLEN / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     in_insn,
  input  logic [PW-1:0]   in_pred,
  input  logic [VLEN-1:0] in_src,
  output logic            out_valid,
  output logic            out_bad,
  output logic [1:0]      out_esz,
  output logic [2:0]      out_pg,
  output logic [4:0]      out_zn,
  output logic [4:0]      out_zd,
  output logic [VLEN-1:0] out_data
);
  if (VLEN % 128 != 0 || VLEN < 128) begin : g_vlen_bad
    $error("vexp_unit: VLEN must be a positive multiple of 128");
  end

  insn_f_t         dec;
  logic [VLEN-1:0] path_res [NUM_ESZ];
  logic [VLEN-1:0] sel_res;

  vexp_decode u_dec (
    .insn   (in_insn),
    .fields (dec)
  );

  for (genvar s = 0; s < NUM_ESZ; s++) begin : g_esz
    vexp_size_path #(.VLEN(VLEN), .EW(elem_bits(s))) u_path (
      .src  (in_src),
      .pred (in_pred),
      .res  (path_res[s])
    );
  end

  always_comb begin
    sel_res = path_res[dec.esz];
    if (dec.bad) sel_res = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bad   <= 1'b0;
      out_data  <= '0;
      out_esz   <= '0;
      out_pg    <= '0;
      out_zn    <= '0;
      out_zd    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_bad  <= dec.bad;
        out_data <= sel_res;
        out_esz  <= dec.esz;
        out_pg   <= dec.pg;
        out_zn   <= dec.zn;
        out_zd   <= dec.zd;
      end
    end
  end
endmodule

// File: rtl/vexp_chk.sv
module vexp_chk #(
  parameter int VLEN = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [31:0]       in_insn,
  input logic [VLEN/8-1:0] in_pred,
  input logic [VLEN-1:0]   in_src,
  input logic              out_valid,
  input logic              out_bad,
  input logic [VLEN-1:0]   out_data
);
  logic word_ok;
  assign word_ok = (in_insn[31:24] == 8'h05) && (in_insn[21:13] == 9'b110001100);

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R8
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R10
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // R7
  bad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_bad |-> out_data == '0);

  // R5
  none_active_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_pred == '0) |=> out_data == '0);

  // R3
  first_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && word_ok && in_pred[0]) |=> out_data[7:0] == $past(in_src[7:0]));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_bad));
endmodule

bind vexp_unit vexp_chk #(.VLEN(VLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_insn   (in_insn),
  .in_pred   (in_pred),
  .in_src    (in_src),
  .out_valid (out_valid),
  .out_bad   (out_bad),
  .out_data  (out_data)
);

// File: tb/vexp_unit_test.sv
module vexp_unit_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         vld = 1'b0;
  logic [31:0]  insn = '0;
  logic [31:0]  pred = '0;
  logic [255:0] src = '0;

  logic         ov_w, bad_w, ov_n, bad_n;
  logic [1:0]   esz_w, esz_n;
  logic [2:0]   pg_w, pg_n;
  logic [4:0]   zn_w, zn_n, zd_w, zd_n;
  logic [255:0] dat_w;
  logic [127:0] dat_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  vexp_unit #(.VLEN(256)) uut (
    .clk(clk), .rst(rst), .in_valid(vld), .in_insn(insn), .in_pred(pred),
    .in_src(src), .out_valid(ov_w), .out_bad(bad_w), .out_esz(esz_w),
    .out_pg(pg_w), .out_zn(zn_w), .out_zd(zd_w), .out_data(dat_w)
  );

  vexp_unit #(.VLEN(128)) uut_narrow (
    .clk(clk), .rst(rst), .in_valid(vld), .in_insn(insn), .in_pred(pred[15:0]),
    .in_src(src[127:0]), .out_valid(ov_n), .out_bad(bad_n), .out_esz(esz_n),
    .out_pg(pg_n), .out_zn(zn_n), .out_zd(zd_n), .out_data(dat_n)
  );

  // size, mask, expected non-zero lanes in the 256-bit build
  localparam int NVEC = 13;
  localparam logic [39:0] VEC [NVEC] = '{
    {2'd0, 32'hFFFF_FFFF, 6'd32},
    {2'd0, 32'h0000_0000, 6'd0},
    {2'd0, 32'h0000_0001, 6'd1},
    {2'd0, 32'h5555_5555, 6'd16},
    {2'd1, 32'hFFFF_FFFF, 6'd16},
    {2'd1, 32'h5555_5555, 6'd16},
    {2'd1, 32'hAAAA_AAAA, 6'd0},
    {2'd2, 32'h1111_1111, 6'd8},
    {2'd2, 32'hEEEE_EEEE, 6'd0},
    {2'd3, 32'h0000_0100, 6'd1},
    {2'd3, 32'h8000_0001, 6'd1},
    {2'd0, 32'h8000_0000, 6'd1},
    {2'd2, 32'h00F0_000F, 6'd2}
  };

  function automatic logic [31:0] mk(input int sz, input int pg, input int zn, input int zd);
    return {8'h05, 2'(sz), 9'b110001100, 3'(pg), 5'(zn), 5'(zd)};
  endfunction

  function automatic logic [255:0] ref_exp(input logic [255:0] s, input logic [31:0] p,
                                           input int sz, input int vl);
    logic [255:0] r;
    int ew, x;
    r = '0;
    ew = 8 << sz;
    x = 0;
    for (int e = 0; e < vl / ew; e++) begin
      if (p[e*ew/8]) begin
        for (int b = 0; b < ew; b++) r[e*ew+b] = s[x*ew+b];
        x++;
      end
    end
    return r;
  endfunction

  function automatic int count_nz(input logic [255:0] d, input int sz, input int vl);
    int ew, c;
    logic any;
    ew = 8 << sz;
    c = 0;
    for (int e = 0; e < vl / ew; e++) begin
      any = 1'b0;
      for (int b = 0; b < ew; b++) any = any | d[e*ew+b];
      if (any) c++;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic [31:0] p, input logic [255:0] s);
    vld  = 1'b1;
    insn = w;
    pred = p;
    src  = s;
  endtask

  task automatic check_both(input string req, input int sz);
    chk({req, " wide"}, dat_w, ref_exp(src, pred, sz, 256));
    chk({req, " narrow"}, {128'd0, dat_n}, ref_exp(src, pred, sz, 128));
  endtask

  initial begin
    logic [255:0] seq;
    logic [255:0] held;
    for (int k = 0; k < 32; k++) seq[k*8 +: 8] = 8'(k + 1);

    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 valid", {255'd0, ov_w}, 256'd0);
    chk("R9 data", dat_w, 256'd0);
    chk("R9 bad", {255'd0, bad_w}, 256'd0);
    rst = 1'b0;

    // table walk: R1 R2 R3 R4 R5 R11
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      drive(mk(int'(VEC[v][39:38]), 1, 2, 3), VEC[v][37:6], seq);
      @(negedge clk);
      vld = 1'b0;
      check_both("R3 R4 table", int'(VEC[v][39:38]));
      chk("R2 R5 active count", 256'(count_nz(dat_w, int'(VEC[v][39:38]), 256)),
          256'(VEC[v][5:0]));
      chk("R1 esz echo", {254'd0, esz_w}, {254'd0, VEC[v][39:38]});
    end

    // R6 decode fields
    @(negedge clk);
    drive(mk(2, 5, 17, 30), 32'h1, seq);
    @(negedge clk);
    vld = 1'b0;
    chk("R6 fields", {243'd0, pg_w, zn_w, zd_w}, {243'd0, 3'd5, 5'd17, 5'd30});
    chk("R6 bad clear", {255'd0, bad_w}, 256'd0);

    // R7 malformed words
    @(negedge clk);
    drive(mk(0, 0, 0, 0) ^ 32'h8000_0000, 32'hFFFF_FFFF, seq);
    @(negedge clk);
    vld = 1'b0;
    chk("R7 bad top", {255'd0, bad_w}, 256'd1);
    chk("R7 zero top", dat_w, 256'd0);
    @(negedge clk);
    drive(mk(1, 0, 0, 0) ^ 32'h0000_2000, 32'hFFFF_FFFF, seq);
    @(negedge clk);
    vld = 1'b0;
    chk("R7 bad mid", {255'd0, bad_n}, 256'd1);
    chk("R7 zero mid", dat_w, 256'd0);

    // R8 back-to-back
    @(negedge clk);
    drive(mk(0, 0, 0, 0), 32'h0000_00F0, seq);
    @(negedge clk);
    chk("R8 first valid", {255'd0, ov_w}, 256'd1);
    check_both("R8 first", 0);
    drive(mk(3, 0, 0, 0), 32'h0101_0000, ~seq);
    @(negedge clk);
    vld = 1'b0;
    chk("R8 second valid", {255'd0, ov_w}, 256'd1);
    check_both("R8 second", 3);
    held = dat_w;

    // R10 hold while idle
    insn = mk(0, 0, 0, 0);
    pred = 32'hFFFF_FFFF;
    src  = seq;
    @(negedge clk);
    chk("R10 idle valid", {255'd0, ov_w}, 256'd0);
    chk("R10 hold data", dat_w, held);

    // random masks at every width, both builds (R3 R4 R11)
    for (int sz = 0; sz < 4; sz++) begin
      for (int r = 0; r < 30; r++) begin
        @(negedge clk);
        drive(mk(sz, r % 8, r, 31 - r), $urandom,
              {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
        @(negedge clk);
        vld = 1'b0;
        check_both("R11 random", sz);
      end
    end

    // R9 reset mid-stream
    @(negedge clk);
    drive(mk(0, 0, 0, 0), 32'hFFFF_FFFF, seq);
    rst = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    rst = 1'b0;
    chk("R9 reset valid", {255'd0, ov_w}, 256'd0);
    chk("R9 reset data", dat_w, 256'd0);

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule